// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block decides which pending processor exception is taken and produces everything the core needs to enter it. Six request lines cover the five exception kinds: a fast interrupt, a normal interrupt, an undefined instruction, a software interrupt used as a supervisor call, and a memory abort split into data and prefetch variants so that each gets its own vector. The controller reads the interrupt mask bits and the instruction-state bit from the current status word. Each kind maps to its own privileged mode.

A small state machine has three named states. ST_IDLE samples the requests. On a clock edge where an unmasked request is present, the transition IDLE->SAVE captures the winning kind and the current status word. ST_SAVE raises a one-cycle save pulse and presents the old status word, so the core can write it into the target mode's saved-status register. The transition SAVE->SWITCH is unconditional. ST_SWITCH raises the take strobe and presents the new mode code, the vector address and the updated status word. The transition SWITCH->IDLE is also unconditional. With no unmasked request the machine stays in ST_IDLE (IDLE->IDLE).

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset the machine is in ST_IDLE, and save_o, take_o, saved_status_o, mode_o, vector_o and status_o are all zero.
- R2: An unmasked request present at a clock edge in ST_IDLE makes save_o high for exactly the next cycle, with saved_status_o equal to status_in as sampled at that edge. take_o is high for exactly the cycle after that, and then the machine is back in ST_IDLE.
- R3: When several unmasked requests are present at once, one is taken in this order, highest first: data abort, prefetch abort, fast interrupt, normal interrupt, undefined instruction, software interrupt.
- R4: A normal interrupt request has no effect while status_in bit 7 is 1. A fast interrupt request has no effect while status_in bit 6 is 1. The abort, undefined and software interrupt requests cannot be masked.
- R5: During take_o, mode_o is 5'b10001 for the fast interrupt, 5'b10010 for the normal interrupt, 5'b10011 for the software interrupt, 5'b10111 for either abort and 5'b11011 for an undefined instruction.
- R6: During take_o, vector_o is 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for normal interrupt and 0x1C for fast interrupt.
- R7: During take_o, status_o equals the captured status word with these changes: bits 4:0 replaced by mode_o, bit 5 (16-bit instruction state) cleared, and bit 7 set. Bit 6 is set for a fast interrupt or either abort and is otherwise kept.
- R8: Requests present while the machine is in ST_SAVE or ST_SWITCH are ignored. The kind being entered does not change.
- R9: saved_status_o is zero outside ST_SAVE, and mode_o, vector_o and status_o are zero outside ST_SWITCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_dabt | input | 1 | Data abort request |
| req_pabt | input | 1 | Prefetch abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| status_in | input | 32 | Current status word (bit 7 normal mask, bit 6 fast mask, bit 5 16-bit state, bits 4:0 mode) |
| save_o | output | 1 | Pulse: save the old status word |
| saved_status_o | output | 32 | Old status word, valid with save_o |
| take_o | output | 1 | Take-exception strobe |
| mode_o | output | 5 | New privileged mode code |
| vector_o | output | 32 | Exception vector address |
| status_o | output | 32 | Updated status word |

## Verification
The assertions assume that the undefined and software interrupt requests never arrive together, because both come from the same instruction slot, and that status_in stays stable from the sampling edge in ST_IDLE until the entry completes. The bench sweeps all request combinations against every mask setting and both instruction states. When the undefined and software interrupt requests are both asserted, the bench expects the fixed order of R3 and does not depend on the assumption above. It holds status_in constant through each entry and raises a competing request only during ST_SAVE to exercise R8.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_DABT = 3'd1,
        K_PABT = 3'd2,
        K_FIQ  = 3'd3,
        K_IRQ  = 3'd4,
        K_UND  = 3'd5,
        K_SWI  = 3'd6
    } exc_kind_e;

    localparam int NSRC   = 6;
    localparam int MODE_W = 5;

    // priority slots, index 0 is highest
    localparam int IDX_DABT = 0;
    localparam int IDX_PABT = 1;
    localparam int IDX_FIQ  = 2;
    localparam int IDX_IRQ  = 3;
    localparam int IDX_UND  = 4;
    localparam int IDX_SWI  = 5;

    localparam logic [NSRC-1:0] MASKABLE = NSRC'((1 << IDX_FIQ) | (1 << IDX_IRQ));

    localparam logic [MODE_W-1:0] M_USR = 5'b10000;
    localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] M_UND = 5'b11011;

    function automatic logic [MODE_W-1:0] kind_mode(input exc_kind_e k);
        logic [MODE_W-1:0] m;
        unique case (k)
            K_DABT, K_PABT: m = M_ABT;
            K_FIQ:          m = M_FIQ;
            K_IRQ:          m = M_IRQ;
            K_UND:          m = M_UND;
            K_SWI:          m = M_SVC;
            default:        m = M_USR;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] kind_offset(input exc_kind_e k);
        logic [7:0] o;
        unique case (k)
            K_UND:   o = 8'h04;
            K_SWI:   o = 8'h08;
            K_PABT:  o = 8'h0C;
            K_DABT:  o = 8'h10;
            K_IRQ:   o = 8'h18;
            K_FIQ:   o = 8'h1C;
            default: o = 8'h00;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int N = NSRC,
    parameter logic [N-1:0] MASK_EN = MASKABLE
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] mask,
    output logic [N-1:0] grant
);
    logic [N-1:0] eff;
    logic [N:0]   seen;

    assign eff     = req & ~(mask & MASK_EN);
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = eff[i] & ~seen[i];
        assign seen[i+1] = seen[i] | eff[i];
    end
endmodule

// File: rtl/exc_entry_fsm.sv
module exc_entry_fsm
    import exc_pkg::*;
#(
    parameter int N     = NSRC,
    parameter int SW    = 32,
    parameter int I_BIT = 7,
    parameter int F_BIT = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  grant,
    input  logic [SW-1:0] status_in,
    output logic          save_o,
    output logic          take_o,
    output exc_kind_e     kind_o,
    output logic [SW-1:0] status_q_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_SAVE, ST_SWITCH} st_e;

    st_e           state, state_nx;
    exc_kind_e     kind_q, kind_enc;
    logic [SW-1:0] status_q;
    logic          hit;

    assign hit = |grant;

    always_comb begin
        kind_enc = K_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (grant[i]) kind_enc = exc_kind_e'(3'(i + 1));
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (hit) state_nx = ST_SAVE;
            ST_SAVE:   state_nx = ST_SWITCH;
            ST_SWITCH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q   <= K_NONE;
            status_q <= '0;
        end else if (state == ST_IDLE && hit) begin
            kind_q   <= kind_enc;
            status_q <= status_in;
        end
    end

    always_comb begin
        save_o = 1'b0;
        take_o = 1'b0;
        unique case (state)
            ST_SAVE:   save_o = 1'b1;
            ST_SWITCH: take_o = 1'b1;
            default:   ;
        endcase
    end

    assign kind_o     = kind_q;
    assign status_q_o = status_q;

    p_save_then_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |=> take_o);
    p_take_after_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(save_o));
    p_kind_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        save_o |=> $stable(kind_q) && $stable(status_q));
    p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && grant[IDX_IRQ]) |-> !status_in[I_BIT]);
    p_fiq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && grant[IDX_FIQ]) |-> !status_in[F_BIT]);
endmodule

// File: rtl/exc_status_builder.sv
module exc_status_builder
    import exc_pkg::*;
#(
    parameter int SW    = 32,
    parameter int AW    = 32,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter int I_BIT = 7,
    parameter int F_BIT = 6,
    parameter int T_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  exc_kind_e         kind,
    input  logic [SW-1:0]     old_status,
    output logic [MODE_W-1:0] mode,
    output logic [AW-1:0]     vector,
    output logic [SW-1:0]     new_status
);
    logic set_f;

    assign mode   = kind_mode(kind);
    assign vector = VEC_BASE + AW'(kind_offset(kind));
    assign set_f  = (kind == K_FIQ) || (kind == K_DABT) || (kind == K_PABT);

    always_comb begin
        new_status             = old_status;
        new_status[MODE_W-1:0] = mode;
        new_status[T_BIT]      = 1'b0;
        new_status[I_BIT]      = 1'b1;
        if (set_f) new_status[F_BIT] = 1'b1;
    end

    p_arm_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> !new_status[T_BIT] && new_status[I_BIT]);
    p_fiq_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode == M_FIQ) |-> vector == VEC_BASE + AW'(8'h1C));
    p_mode_priv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> mode != M_USR);
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int SW    = 32,
    parameter int AW    = 32,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter int I_BIT = 7,
    parameter int F_BIT = 6,
    parameter int T_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_dabt,
    input  logic              req_pabt,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_und,
    input  logic              req_swi,
    input  logic [SW-1:0]     status_in,
    output logic              save_o,
    output logic [SW-1:0]     saved_status_o,
    output logic              take_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [AW-1:0]     vector_o,
    output logic [SW-1:0]     status_o
);
    logic [NSRC-1:0]   req_v, mask_v, grant;
    logic              save_w, take_w;
    exc_kind_e         kind;
    logic [SW-1:0]     old_status, new_status;
    logic [MODE_W-1:0] mode_w;
    logic [AW-1:0]     vec_w;

    always_comb begin
        req_v           = '0;
        req_v[IDX_DABT] = req_dabt;
        req_v[IDX_PABT] = req_pabt;
        req_v[IDX_FIQ]  = req_fiq;
        req_v[IDX_IRQ]  = req_irq;
        req_v[IDX_UND]  = req_und;
        req_v[IDX_SWI]  = req_swi;
        mask_v          = '0;
        mask_v[IDX_FIQ] = status_in[F_BIT];
        mask_v[IDX_IRQ] = status_in[I_BIT];
    end

    exc_arbiter #(.N(NSRC), .MASK_EN(MASKABLE)) u_arb (
        .req   (req_v),
        .mask  (mask_v),
        .grant (grant)
    );

    exc_entry_fsm #(.N(NSRC), .SW(SW), .I_BIT(I_BIT), .F_BIT(F_BIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .status_in  (status_in),
        .save_o     (save_w),
        .take_o     (take_w),
        .kind_o     (kind),
        .status_q_o (old_status)
    );

    exc_status_builder #(
        .SW(SW), .AW(AW), .VEC_BASE(VEC_BASE),
        .I_BIT(I_BIT), .F_BIT(F_BIT), .T_BIT(T_BIT)
    ) u_bld (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (take_w),
        .kind       (kind),
        .old_status (old_status),
        .mode       (mode_w),
        .vector     (vec_w),
        .new_status (new_status)
    );

    assign save_o         = save_w;
    assign take_o         = take_w;
    assign saved_status_o = save_w ? old_status : '0;
    assign mode_o         = take_w ? mode_w     : '0;
    assign vector_o       = take_w ? vec_w      : '0;
    assign status_o       = take_w ? new_status : '0;

    p_quiet_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (mode_o == '0 && vector_o == '0 && status_o == '0));
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(save_o && take_o));
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        r_dabt = 0, r_pabt = 0, r_fiq = 0, r_irq = 0, r_und = 0, r_swi = 0;
    logic [31:0] st_in = '0;
    logic        save_o, take_o;
    logic [31:0] saved_o, vec_o, stat_o;
    logic [4:0]  mode_o;
    int          errors = 0;
    int          checks = 0;

    always #10 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_dabt(r_dabt), .req_pabt(r_pabt), .req_fiq(r_fiq),
        .req_irq(r_irq), .req_und(r_und), .req_swi(r_swi),
        .status_in(st_in), .save_o(save_o), .saved_status_o(saved_o),
        .take_o(take_o), .mode_o(mode_o), .vector_o(vec_o), .status_o(stat_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // kind: 0 none, 1 dabt, 2 pabt, 3 fiq, 4 irq, 5 und, 6 swi
    function automatic int pick(input logic [5:0] rq, input logic im, input logic fm);
        if (rq[0]) return 1;
        if (rq[1]) return 2;
        if (rq[2] && !fm) return 3;
        if (rq[3] && !im) return 4;
        if (rq[4]) return 5;
        if (rq[5]) return 6;
        return 0;
    endfunction

    function automatic logic [4:0] exp_mode(input int k);
        case (k)
            1, 2: return 5'b10111;
            3: return 5'b10001;
            4: return 5'b10010;
            5: return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction

    function automatic logic [31:0] exp_vec(input int k);
        case (k)
            1: return 32'h10;
            2: return 32'h0C;
            3: return 32'h1C;
            4: return 32'h18;
            5: return 32'h04;
            default: return 32'h08;
        endcase
    endfunction

    task automatic set_req(input logic [5:0] rq);
        {r_swi, r_und, r_irq, r_fiq, r_pabt, r_dabt} = rq;
    endtask

    task automatic check_quiet(input string tag);
        chk(save_o == 0 && take_o == 0, tag, {30'b0, save_o, take_o}, 32'h0);
        chk(saved_o == 0 && mode_o == 0 && vec_o == 0 && stat_o == 0, tag,
            saved_o | vec_o | stat_o | {27'b0, mode_o}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_quiet("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet("R1 after release");

        for (int rq = 0; rq < 64; rq++) begin
            for (int m = 0; m < 4; m++) begin
                for (int t = 0; t < 2; t++) begin
                    logic [31:0] s;
                    logic [31:0] ns;
                    int k;
                    s = {24'h5AC300 ^ 24'(rq * 24'h010203 + m), m[1], m[0], t[0], 5'b10000};
                    st_in = s;
                    set_req(rq[5:0]);
                    k = pick(rq[5:0], m[1], m[0]);
                    @(negedge clk);
                    if (k == 0) begin
                        check_quiet("R4 masked or no request");
                        set_req(6'b0);
                    end else begin
                        chk(save_o == 1 && take_o == 0, "R2 save pulse", {30'b0, save_o, take_o}, 32'h2);
                        chk(saved_o == s, "R2 saved status", saved_o, s);
                        chk(mode_o == 0 && vec_o == 0, "R9 quiet during save", vec_o | {27'b0, mode_o}, 32'h0);
                        set_req(6'b0);
                        @(negedge clk);
                        ns = s;
                        ns[4:0] = exp_mode(k);
                        ns[5] = 1'b0;
                        ns[7] = 1'b1;
                        if (k <= 3) ns[6] = 1'b1;
                        chk(take_o == 1 && save_o == 0, "R2 take strobe", {30'b0, save_o, take_o}, 32'h1);
                        chk(mode_o == exp_mode(k), "R3 R5 mode", {27'b0, mode_o}, {27'b0, exp_mode(k)});
                        chk(vec_o == exp_vec(k), "R3 R6 vector", vec_o, exp_vec(k));
                        chk(stat_o == ns, "R7 new status", stat_o, ns);
                        chk(saved_o == 0, "R9 saved cleared", saved_o, 32'h0);
                        @(negedge clk);
                        check_quiet("R2 back to idle");
                    end
                end
            end
        end

        // R8: a higher request raised during ST_SAVE is ignored
        st_in = 32'h0000_0010;
        set_req(6'b100000);
        @(negedge clk);
        chk(save_o == 1, "R8 save for swi", {31'b0, save_o}, 32'h1);
        set_req(6'b000001);
        @(negedge clk);
        chk(mode_o == 5'b10011, "R8 mode stays supervisor", {27'b0, mode_o}, 32'h13);
        chk(vec_o == 32'h08, "R8 vector stays swi", vec_o, 32'h08);
        set_req(6'b0);
        @(negedge clk);
        check_quiet("R8 idle after entry");
        @(negedge clk);
        check_quiet("R8 no late entry");

        // R4: unmaskable sources still taken with both masks set
        st_in = 32'h0000_00D0;
        set_req(6'b010000);
        @(negedge clk);
        chk(save_o == 1, "R4 undefined not maskable", {31'b0, save_o}, 32'h1);
        set_req(6'b0);
        @(negedge clk);
        chk(mode_o == 5'b11011, "R4 undefined mode", {27'b0, mode_o}, 32'h1B);
        @(negedge clk);
        summary();
    end
endmodule